// File: doc/BRIEF.md
# Backplane Window Switch Sequencer

This block points a host-side access window at one core of an on-chip backplane, and at one of two segments inside that core. It does so by programming a small bank of byte-wide configuration registers through a simple request/completion port. Every change is verified: the block writes the window registers, reads them back, and compares the result with what was asked for. On a mismatch it waits a fixed pause and runs the whole write/read sequence again. It reports an error once a bounded number of attempts has been used up.

A client raises `req_valid` for one cycle with a request kind. Kind 0 asks for a core switch by index. Kind 1 asks for a segment switch, 0 or 1. The block then raises `busy` and finishes with a one-cycle `done` or `err` pulse. The confirmed core and segment are kept in `core_cur` and `seg_cur`. As soon as reset is released the block runs a segment-0 switch on its own, so that its recorded segment matches the hardware.

Top module: `bpwin_seq`

## Requirements
- R1: For a core switch with index k, the window base is A = ENUM_BASE + k * 2^REGION_LG (32 bits). The byte written to offset 0x2E is {4'h0, A[15:12]}, to offset 0x30 is A[23:16], and to offset 0x32 is A[31:24].
- R2: One core attempt makes six accesses in this order: write 0x2E, write 0x30, write 0x32, then read 0x2E, read 0x30, read 0x32 (`cfg_we` is 1 for writes). Each access keeps `cfg_req`, `cfg_addr` and `cfg_we` steady until `cfg_ack` or `cfg_fail` is seen.
- R3: For the readback, only bits 3:0 of the 0x2E byte are used. The readback is rebuilt as {rd32, rd30, rd2E[3:0], 12'h000}. The core index is computed as (rebuilt - ENUM_BASE) >> REGION_LG. When it equals the request, `done` pulses and `core_cur` takes the index.
- R4: One segment attempt writes {7'b0, s} to offset 0x34 and then reads 0x34. A readback byte equal to {7'b0, s} gives `done` and sets `seg_cur` to s.
- R5: After a mismatching readback the block waits at least PAUSE_CYC cycles between the last read's completion and the next request. It then repeats the whole attempt, starting from its first write.
- R6: If MAX_RETRY+2 attempts in a row all mismatch, `err` pulses, no further access is made, and `core_cur`/`seg_cur` keep their values.
- R7: A `cfg_fail` completion on any access ends the switch at once with `err`. No further access follows, and the recorded state is unchanged.
- R8: `busy` is high from an accepted request until the cycle in which `done` or `err` pulses. A `req_valid` while `busy` is high is ignored, starts no access, and changes no state.
- R9: Out of reset `busy` is high and the block runs a segment switch to 0 by itself. Its first access is a write of 8'h00 to offset 0x34.
- R10: `done` and `err` are one-cycle pulses, never both high. In that cycle `busy` is already low, and `cfg_req` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle switch request |
| req_kind | input | 1 | 0 = core switch, 1 = segment switch |
| req_core | input | CORE_W | Requested core index |
| req_seg | input | 1 | Requested segment |
| busy | output | 1 | Switch in progress |
| done | output | 1 | Switch confirmed (pulse) |
| err | output | 1 | Switch failed (pulse) |
| core_cur | output | CORE_W | Last confirmed core index |
| seg_cur | output | 1 | Last confirmed segment |
| cfg_req | output | 1 | Configuration access strobe, held until completion |
| cfg_we | output | 1 | 1 = write, 0 = read |
| cfg_addr | output | 8 | Configuration register offset |
| cfg_wdata | output | 8 | Write byte |
| cfg_rdata | input | 8 | Read byte, valid with cfg_ack |
| cfg_ack | input | 1 | Access completed normally |
| cfg_fail | input | 1 | Access completed with error |

## Verification
The bench fills the upper nibble of the 0x2E readback with random bits. A design that fails to mask those bits sees mismatches that never clear, so it retries until it reports an error on switches that should succeed. The bench also corrupts the readback for a chosen number of attempts, including exactly MAX_RETRY+1 and MAX_RETRY+2. This pins the retry boundary, where an off-by-one design either gives up one attempt early or makes one access set too many. Error completions are injected at random access positions, and a design that keeps going after one shows extra accesses or a stray `done`. Measuring the gap between attempts catches a design that skips or shortens the pause. A request issued while a switch is running catches a design that lets a new request replace the running one.

// File: rtl/bpwin_pkg.sv
package bpwin_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WRITE,
        ST_READ,
        ST_CHECK,
        ST_PAUSE
    } state_e;

    // configuration register offsets; the neighbour decodes these
    localparam logic [7:0] OFS_WIN_LO  = 8'h2E;
    localparam logic [7:0] OFS_WIN_MID = 8'h30;
    localparam logic [7:0] OFS_WIN_HI  = 8'h32;
    localparam logic [7:0] OFS_SEG     = 8'h34;

    localparam logic KIND_CORE = 1'b0;
    localparam logic KIND_SEG  = 1'b1;

endpackage

// File: rtl/bpwin_pause.sv
module bpwin_pause #(
    parameter int PAUSE_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CNT_W = $clog2(PAUSE_CYC + 1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] chk;
    } pause_t;

    pause_t s_q, s_d;

    always_comb begin
        s_d    = s_q;
        expire = s_q.run && (s_q.cnt == '0);
        if (start) begin
            s_d.run = 1'b1;
            s_d.cnt = CNT_W'(PAUSE_CYC - 1);
            s_d.chk = '0;
        end else if (expire) begin
            s_d.run = 1'b0;
        end else if (s_q.run) begin
            s_d.cnt = s_q.cnt - 1'b1;
            s_d.chk = s_q.chk + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // elapsed-cycle counter runs up independently of the down counter
    p_pause_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> (s_q.chk == CNT_W'(PAUSE_CYC - 1)));

endmodule

// File: rtl/bpwin_addr.sv
module bpwin_addr #(
    parameter int          CORE_W    = 5,
    parameter int          REGION_LG = 12,
    parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
    input  logic              kind,
    input  logic [1:0]        step,
    input  logic [CORE_W-1:0] core,
    input  logic              seg,
    output logic [7:0]        ofs,
    output logic [7:0]        wbyte
);
    import bpwin_pkg::*;

    logic [31:0] base;

    always_comb begin
        base  = ENUM_BASE + (32'(core) << REGION_LG);
        ofs   = OFS_SEG;
        wbyte = {7'b0, seg};
        if (kind == KIND_CORE) begin
            unique case (step)
                2'd0:    begin ofs = OFS_WIN_LO;  wbyte = {4'h0, base[15:12]}; end
                2'd1:    begin ofs = OFS_WIN_MID; wbyte = base[23:16];         end
                default: begin ofs = OFS_WIN_HI;  wbyte = base[31:24];         end
            endcase
        end
    end

endmodule

// File: rtl/bpwin_match.sv
module bpwin_match #(
    parameter int          CORE_W    = 5,
    parameter int          REGION_LG = 12,
    parameter logic [31:0] ENUM_BASE = 32'h1800_0000
) (
    input  logic              kind,
    input  logic [CORE_W-1:0] core,
    input  logic              seg,
    input  logic [7:0]        rb_lo,
    input  logic [7:0]        rb_mid,
    input  logic [7:0]        rb_hi,
    output logic              hit
);
    import bpwin_pkg::*;

    logic [31:0] rebuilt;
    logic [31:0] idx;

    always_comb begin
        rebuilt = {rb_hi, rb_mid, rb_lo[3:0], 12'h000};
        idx     = (rebuilt - ENUM_BASE) >> REGION_LG;
        if (kind == KIND_CORE) hit = (idx == 32'(core));
        else                   hit = (rb_lo == {7'b0, seg});
    end

endmodule

// File: rtl/bpwin_seq.sv
module bpwin_seq #(
    parameter int          CORE_W    = 5,
    parameter int          REGION_LG = 12,
    parameter logic [31:0] ENUM_BASE = 32'h1800_0000,
    parameter int          MAX_RETRY = 3,
    parameter int          PAUSE_CYC = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_kind,
    input  logic [CORE_W-1:0] req_core,
    input  logic              req_seg,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [CORE_W-1:0] core_cur,
    output logic              seg_cur,
    output logic              cfg_req,
    output logic              cfg_we,
    output logic [7:0]        cfg_addr,
    output logic [7:0]        cfg_wdata,
    input  logic [7:0]        cfg_rdata,
    input  logic              cfg_ack,
    input  logic              cfg_fail
);
    import bpwin_pkg::*;

    localparam int TRY_W = $clog2(MAX_RETRY + 3);

    typedef struct packed {
        state_e            st;
        logic              kind;
        logic [CORE_W-1:0] tgt_core;
        logic              tgt_seg;
        logic [1:0]        step;
        logic [TRY_W-1:0]  tries;
        logic [7:0]        rb_lo;
        logic [7:0]        rb_mid;
        logic [7:0]        rb_hi;
        logic              done;
        logic              err;
        logic              seg_cur;
        logic [CORE_W-1:0] core_cur;
    } ctl_t;

    ctl_t c_q, c_d;
    logic pause_go, pause_end, hit;
    logic [1:0] last_step;

    bpwin_addr #(.CORE_W(CORE_W), .REGION_LG(REGION_LG), .ENUM_BASE(ENUM_BASE)) i_addr (
        .kind (c_q.kind), .step (c_q.step), .core (c_q.tgt_core), .seg (c_q.tgt_seg),
        .ofs  (cfg_addr), .wbyte (cfg_wdata)
    );

    bpwin_match #(.CORE_W(CORE_W), .REGION_LG(REGION_LG), .ENUM_BASE(ENUM_BASE)) i_match (
        .kind  (c_q.kind), .core (c_q.tgt_core), .seg (c_q.tgt_seg),
        .rb_lo (c_q.rb_lo), .rb_mid (c_q.rb_mid), .rb_hi (c_q.rb_hi), .hit (hit)
    );

    bpwin_pause #(.PAUSE_CYC(PAUSE_CYC)) i_pause (
        .clk (clk), .rst_n (rst_n), .start (pause_go), .expire (pause_end)
    );

    always_comb begin
        c_d       = c_q;
        c_d.done  = 1'b0;
        c_d.err   = 1'b0;
        pause_go  = 1'b0;
        last_step = (c_q.kind == KIND_CORE) ? 2'd2 : 2'd0;
        unique case (c_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    c_d.st       = ST_WRITE;
                    c_d.kind     = req_kind;
                    c_d.tgt_core = req_core;
                    c_d.tgt_seg  = req_seg;
                    c_d.step     = 2'd0;
                    c_d.tries    = '0;
                end
            end
            ST_WRITE: begin
                if (cfg_fail) begin
                    c_d.st  = ST_IDLE;
                    c_d.err = 1'b1;
                end else if (cfg_ack) begin
                    if (c_q.step == last_step) begin
                        c_d.st   = ST_READ;
                        c_d.step = 2'd0;
                    end else begin
                        c_d.step = c_q.step + 2'd1;
                    end
                end
            end
            ST_READ: begin
                if (cfg_fail) begin
                    c_d.st  = ST_IDLE;
                    c_d.err = 1'b1;
                end else if (cfg_ack) begin
                    unique case (c_q.step)
                        2'd0:    c_d.rb_lo  = cfg_rdata;
                        2'd1:    c_d.rb_mid = cfg_rdata;
                        default: c_d.rb_hi  = cfg_rdata;
                    endcase
                    if (c_q.step == last_step) c_d.st   = ST_CHECK;
                    else                       c_d.step = c_q.step + 2'd1;
                end
            end
            ST_CHECK: begin
                if (hit) begin
                    c_d.st   = ST_IDLE;
                    c_d.done = 1'b1;
                    if (c_q.kind == KIND_CORE) c_d.core_cur = c_q.tgt_core;
                    else                       c_d.seg_cur  = c_q.tgt_seg;
                end else if (c_q.tries > TRY_W'(MAX_RETRY)) begin
                    c_d.st  = ST_IDLE;
                    c_d.err = 1'b1;
                end else begin
                    c_d.st    = ST_PAUSE;
                    c_d.tries = c_q.tries + 1'b1;
                    pause_go  = 1'b1;
                end
            end
            ST_PAUSE: begin
                if (pause_end) begin
                    c_d.st   = ST_WRITE;
                    c_d.step = 2'd0;
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q          <= '0;
            c_q.st       <= ST_WRITE;  // bring the segment select to a known value
            c_q.kind     <= KIND_SEG;
            c_q.tgt_seg  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign busy     = (c_q.st != ST_IDLE);
    assign done     = c_q.done;
    assign err      = c_q.err;
    assign core_cur = c_q.core_cur;
    assign seg_cur  = c_q.seg_cur;
    assign cfg_req  = (c_q.st == ST_WRITE) || (c_q.st == ST_READ);
    assign cfg_we   = (c_q.st == ST_WRITE);

    p_strobe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && !cfg_ack && !cfg_fail) |=> (cfg_req && $stable(cfg_addr) && $stable(cfg_we)));

    p_tries_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        c_q.tries <= TRY_W'(MAX_RETRY + 1));

    p_fail_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_req && cfg_fail) |=> (err && !cfg_req));

    p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || err));

    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));

    p_pulse_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy);

    p_done_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_quiet_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cfg_req);

endmodule

// File: tb/test_bpwin_seq.sv
module test_bpwin_seq;
    localparam int          CW    = 5;
    localparam int          LG    = 12;
    localparam logic [31:0] BASE  = 32'h1800_0000;
    localparam int          MAXR  = 3;
    localparam int          PAUSE = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_kind = 1'b0, req_seg = 1'b0;
    logic [CW-1:0] req_core = '0;
    logic busy, done, err, seg_cur, cfg_req, cfg_we;
    logic [CW-1:0] core_cur;
    logic [7:0] cfg_addr, cfg_wdata;
    logic [7:0] cfg_rdata = 8'h00;
    logic cfg_ack = 1'b0, cfg_fail = 1'b0;

    always #2.5 clk = ~clk;

    bpwin_seq #(.CORE_W(CW), .REGION_LG(LG), .ENUM_BASE(BASE), .MAX_RETRY(MAXR),
                .PAUSE_CYC(PAUSE)) i_bpwin_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_core(req_core), .req_seg(req_seg), .busy(busy), .done(done), .err(err),
        .core_cur(core_cur), .seg_cur(seg_cur), .cfg_req(cfg_req), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .cfg_ack(cfg_ack), .cfg_fail(cfg_fail)
    );

    int errors = 0, checks = 0, cyc = 0;
    int n_acc = 0, knob_bad = 0, knob_fail = -1, cur_per = 2;
    logic [7:0] regs [0:255];
    logic       log_we   [0:63];
    logic [7:0] log_addr [0:63];
    logic [7:0] log_data [0:63];
    int         log_start[0:63];
    int         log_ack  [0:63];
    int model_core = 0, model_seg = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int core, input int pos);
        logic [31:0] a;
        a = BASE + (32'(core) << LG);
        if (pos == 0) return {4'h0, a[15:12]};
        if (pos == 1) return a[23:16];
        return a[31:24];
    endfunction

    function automatic logic [7:0] exp_ofs(input bit kind, input int pos);
        if (kind) return 8'h34;
        return 8'h2E + 8'(2 * (pos % 3));
    endfunction

    // configuration register model with fault injection
    initial begin
        for (int i = 0; i < 256; i++) regs[i] = 8'($urandom_range(0, 255));
        regs[8'h34] = 8'h01;
        forever begin
            @(negedge clk);
            cfg_ack  = 1'b0;
            cfg_fail = 1'b0;
            if (cfg_req && rst_n) begin
                automatic int lat = $urandom_range(0, 2);
                automatic int k   = n_acc;
                if (k < 64) log_start[k] = cyc;
                repeat (lat) @(negedge clk);
                if (k < 64) begin
                    log_we[k] = cfg_we; log_addr[k] = cfg_addr;
                    log_data[k] = cfg_we ? cfg_wdata : 8'h00; log_ack[k] = cyc;
                end
                if (k == knob_fail) begin
                    cfg_fail = 1'b1;
                end else begin
                    if (cfg_we) regs[cfg_addr] = cfg_wdata;
                    else begin
                        cfg_rdata = regs[cfg_addr];
                        if (cfg_addr == 8'h2E)
                            cfg_rdata[7:4] = 4'($urandom_range(0, 15));
                        if ((cfg_addr == 8'h32 || cfg_addr == 8'h34) && (k / cur_per) < knob_bad)
                            cfg_rdata = cfg_rdata ^ ((cfg_addr == 8'h32) ? 8'h01 : 8'h03);
                    end
                    cfg_ack = 1'b1;
                end
                n_acc++;
            end
        end
    end

    task automatic run_op(input bit kind, input int core, input bit seg, input int bad,
                          input int fail_at, input bit poke);
        int per, natt, total, mism, mingap;
        bit exp_err, got;
        per = kind ? 2 : 6;
        cur_per = per; knob_bad = bad; knob_fail = fail_at; n_acc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_core = CW'(core); req_seg = seg;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R8 busy after request", busy, 1);
        got = 0;
        for (int i = 0; i < 6000 && !got; i++) begin
            if (poke && i == 4) begin
                req_valid = 1'b1; req_kind = ~kind; req_core = CW'(core + 1); req_seg = ~seg;
            end else req_valid = 1'b0;
            if (done || err) got = 1;
            else @(negedge clk);
        end
        req_valid = 1'b0;
        natt = (bad >= MAXR + 2) ? MAXR + 2 : bad + 1;
        exp_err = (bad >= MAXR + 2);
        total = natt * per;
        if (fail_at >= 0 && fail_at < total) begin exp_err = 1; total = fail_at + 1; end
        chk(got && (err == exp_err) && (done == !exp_err),
            kind ? "R4/R6/R7 outcome" : "R3/R6/R7 outcome", int'(err), int'(exp_err));
        chk(n_acc == total, "R5/R6/R7 access count", n_acc, total);
        mism = 0;
        for (int i = 0; i < n_acc && i < 64; i++) begin
            automatic int pos = i % per;
            automatic bit wr = kind ? (pos == 0) : (pos < 3);
            automatic logic [7:0] wd = kind ? {7'b0, seg} : exp_byte(core, pos);
            if (log_we[i] != wr || log_addr[i] != exp_ofs(kind, pos)) mism++;
            if (wr && log_data[i] != wd) mism++;
        end
        chk(mism == 0, kind ? "R4 sequence" : "R1/R2 sequence", mism, 0);
        mingap = 1 << 30;
        for (int a = 1; a * per < n_acc; a++) begin
            automatic int g = log_start[a * per] - log_ack[a * per - 1];
            if (g < mingap) mingap = g;
        end
        if (n_acc > per) chk(mingap >= PAUSE, "R5 pause gap", mingap, PAUSE);
        if (!exp_err) begin
            if (kind) model_seg = seg; else model_core = core;
        end
        chk(int'(core_cur) == model_core && int'(seg_cur) == model_seg,
            "R3/R4/R6 recorded state", int'(core_cur) * 2 + int'(seg_cur),
            model_core * 2 + model_seg);
        @(negedge clk);
        chk(!done && !err && !busy, "R10 single pulse", int'(done) + int'(err), 0);
        if (poke) begin
            repeat (20) @(negedge clk);
            chk(!busy && n_acc == total, "R8 request ignored while busy", n_acc, total);
        end
    endtask

    initial begin
        automatic int seed = $urandom(32'd2024);
        if (seed < 0) $display("seed");
        repeat (4) @(negedge clk);
        chk(busy == 1'b1 && cfg_req == 1'b1, "R9 busy in reset", busy, 1);
        rst_n = 1'b1;
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        chk(done == 1'b1 && n_acc == 2, "R9 start-up switch", n_acc, 2);
        chk(log_we[0] && log_addr[0] == 8'h34 && log_data[0] == 8'h00,
            "R9 first write", int'(log_addr[0]), 8'h34);
        chk(seg_cur == 1'b0, "R9 segment zero", seg_cur, 0);
        @(negedge clk);
        // directed corners
        run_op(1'b0, 31, 1'b0, 0, -1, 1'b0);
        run_op(1'b0, 7, 1'b0, MAXR + 1, -1, 1'b0);
        run_op(1'b0, 9, 1'b0, MAXR + 2, -1, 1'b0);
        run_op(1'b1, 0, 1'b1, 1, -1, 1'b0);
        run_op(1'b1, 0, 1'b0, MAXR + 2, -1, 1'b0);
        run_op(1'b0, 12, 1'b0, 0, 4, 1'b0);
        run_op(1'b1, 0, 1'b1, 0, 0, 1'b0);
        run_op(1'b0, 3, 1'b0, 2, -1, 1'b1);
        // constrained random mix
        for (int t = 0; t < 24; t++) begin
            automatic bit k  = 1'($urandom_range(0, 1));
            automatic int cr = $urandom_range(0, 31);
            automatic bit sg = 1'($urandom_range(0, 1));
            automatic int bd = $urandom_range(0, MAXR + 2);
            automatic int fa = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 20) : -1;
            run_op(k, cr, sg, bd, fa, 1'b0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule